// File: doc/BRIEF.md
# Dual-Core Time-Slice Arbiter

This block decides which of two processors may execute at any moment. One processor (the fast core) runs at twice the clock rate of the other (the slow core). The grant alternates between them in slices. Slice lengths are not a fixed quantum. A signed drift accumulator records how far the fast core has run ahead of the slow core. Each new slice length is derived from that accumulator, so that over many slices the slow core completes one cycle for every two fast-core cycles.

Time arrives on `tickCnt`. Each clock it carries the number of fast-core cycles that elapsed in that clock, and the value may be zero. A slice therefore usually ends with some overshoot. That overshoot is charged to the core that ran, and it feeds into the next slice length. On every switch the block flips a one-hot grant, publishes the new slice length and raises a one-clock pulse.

Top module: `timeslice_arbiter`

## Requirements
- R1: While `rstN` is low and on the first clock after it rises, `grant` is 2'b01 (bit 0 is the fast core, bit 1 is the slow core), `sliceLen` is 2048 and `switchPulse` is 0. The drift starts at 0.
- R2: Each clock, `tickCnt` fast-core cycles are added to the running slice. A clock with `tickCnt` equal to 0 changes neither the grant nor the slice length.
- R3: A fast-core slice ends on the first clock edge at which its accumulated fast-core cycles reach or exceed `sliceLen`. A slow-core slice ends on the first edge at which its accumulated fast-core cycles reach or exceed twice `sliceLen`. `grant` flips on that same edge.
- R4: When a fast-core slice ends, all of its accumulated fast-core cycles, overshoot included, are added to the drift. The slow core's slice length is then the new drift arithmetically shifted right by one.
- R5: When a slow-core slice ends, the number of slow-core cycles consumed is its accumulated fast-core cycles divided by two, rounded down. Twice that number is subtracted from the drift. The fast core's slice length is then the new drift plus 2048.
- R6: A computed slice length that is zero or negative is replaced by 1. A negative drift at the end of a fast-core slice uses a sign-preserving shift, so it clamps to 1.
- R7: `switchPulse` is high for exactly the one clock that follows each edge at which `grant` changed, and it is low at every other time.
- R8: `grant` has exactly one bit set at all times.
- R9: The cycle count of a slice restarts from zero at each switch. Overshoot from one slice never counts toward the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickCnt | input | TICK_W (12) | Fast-core cycles elapsed in this clock |
| grant | output | 2 | One-hot grant: bit 0 fast core, bit 1 slow core |
| sliceLen | output | DRIFT_W (24) | Length of the current slice, in the granted core's own cycles |
| switchPulse | output | 1 | One-clock pulse when the grant changes |

## Verification
The bench drives one large tick into a slow slice whose remaining length is much shorter. This pushes the drift far below zero. A design that shifted logically, or that did not clamp, would then report a huge slice length or a zero-length slice that never ends. The bench also ends slow slices on an odd count of fast cycles. A design that subtracted the raw count instead of the even part would let the drift walk away from the reference. A design that carried overshoot into the next slice would switch one tick too early. Zero ticks and long random tick streams check that the grant holds still between boundaries, and that the pulse appears only on the clock that follows a grant change.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

  // Strobes from the slice control to the drift datapath.
  typedef struct packed {
    logic closeFast;  // fast-core slice ended on this edge
    logic closeSlow;  // slow-core slice ended on this edge
  } sliceStrobe_t;

  // Grant bit positions.
  localparam int FAST_IDX = 0;
  localparam int SLOW_IDX = 1;

endpackage

// File: rtl/tsa_ctrl.sv
module tsa_ctrl
  import tsa_pkg::*;
#(
  parameter int DRIFT_W = 24,
  parameter int TICK_W  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TICK_W-1:0]  tickCnt,
  input  logic [DRIFT_W-1:0] sliceLen,
  output sliceStrobe_t       strobe,
  output logic [DRIFT_W-1:0] consumed,
  output logic [1:0]         grant,
  output logic               switchPulse
);

  logic               fastActive;
  logic [DRIFT_W-1:0] elapsed;
  logic [DRIFT_W-1:0] elapsedNext;
  logic [DRIFT_W-1:0] target;
  logic               sliceDone;

  // Running count always in fast-core cycles; the slow core needs two per cycle.
  always_comb begin
    elapsedNext = elapsed + DRIFT_W'(tickCnt);
    target      = fastActive ? sliceLen : (sliceLen << 1);
    sliceDone   = (elapsedNext >= target);
  end

  always_comb begin
    strobe.closeFast = sliceDone && fastActive;
    strobe.closeSlow = sliceDone && !fastActive;
    consumed         = elapsedNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fastActive  <= 1'b1;
      elapsed     <= '0;
      switchPulse <= 1'b0;
    end else begin
      switchPulse <= sliceDone;
      if (sliceDone) begin
        fastActive <= !fastActive;
        elapsed    <= '0;
      end else begin
        elapsed <= elapsedNext;
      end
    end
  end

  always_comb begin
    grant           = '0;
    grant[FAST_IDX] = fastActive;
    grant[SLOW_IDX] = !fastActive;
  end

endmodule

// File: rtl/tsa_dp.sv
module tsa_dp
  import tsa_pkg::*;
#(
  parameter int DRIFT_W = 24,
  parameter int NOMINAL = 2048
) (
  input  logic               clk,
  input  logic               rstN,
  input  sliceStrobe_t       strobe,
  input  logic [DRIFT_W-1:0] consumed,
  output logic [DRIFT_W-1:0] sliceLen
);

  localparam logic signed [DRIFT_W-1:0] NOM_S = DRIFT_W'(NOMINAL);
  localparam logic signed [DRIFT_W-1:0] ONE_S = DRIFT_W'(1);

  logic signed [DRIFT_W-1:0] drift;
  logic signed [DRIFT_W-1:0] driftAfterFast;
  logic signed [DRIFT_W-1:0] driftAfterSlow;
  logic signed [DRIFT_W-1:0] rawSlowLen;
  logic signed [DRIFT_W-1:0] rawFastLen;
  logic signed [DRIFT_W-1:0] evenConsumed;

  function automatic logic signed [DRIFT_W-1:0] clampLen(input logic signed [DRIFT_W-1:0] v);
    return (v <= 0) ? ONE_S : v;
  endfunction

  always_comb begin
    evenConsumed   = signed'({consumed[DRIFT_W-1:1], 1'b0});
    driftAfterFast = drift + signed'(consumed);
    driftAfterSlow = drift - evenConsumed;
    rawSlowLen     = driftAfterFast >>> 1;
    rawFastLen     = driftAfterSlow + NOM_S;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drift    <= '0;
      sliceLen <= DRIFT_W'(NOMINAL);
    end else if (strobe.closeFast) begin
      drift    <= driftAfterFast;
      sliceLen <= clampLen(rawSlowLen);
    end else if (strobe.closeSlow) begin
      drift    <= driftAfterSlow;
      sliceLen <= clampLen(rawFastLen);
    end
  end

endmodule

// File: rtl/timeslice_arbiter.sv
module timeslice_arbiter
  import tsa_pkg::*;
#(
  parameter int DRIFT_W = 24,
  parameter int TICK_W  = 12,
  parameter int NOMINAL = 2048
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TICK_W-1:0]  tickCnt,
  output logic [1:0]         grant,
  output logic [DRIFT_W-1:0] sliceLen,
  output logic               switchPulse
);

  sliceStrobe_t       strobe;
  logic [DRIFT_W-1:0] consumed;

  tsa_ctrl #(.DRIFT_W(DRIFT_W), .TICK_W(TICK_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tickCnt    (tickCnt),
    .sliceLen   (sliceLen),
    .strobe     (strobe),
    .consumed   (consumed),
    .grant      (grant),
    .switchPulse(switchPulse)
  );

  tsa_dp #(.DRIFT_W(DRIFT_W), .NOMINAL(NOMINAL)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .consumed(consumed),
    .sliceLen(sliceLen)
  );

endmodule

// File: rtl/tsa_checker.sv
module tsa_checker #(
  parameter int DRIFT_W = 24
) (
  input logic               clk,
  input logic               rstN,
  input logic [1:0]         grant,
  input logic [DRIFT_W-1:0] sliceLen,
  input logic               switchPulse
);

  AST_GRANT_ONE_HOT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(grant) == 1);  // R8

  AST_PULSE_ON_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    (grant != $past(grant)) |-> switchPulse);  // R7

  AST_PULSE_ONLY_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    switchPulse |-> (grant != $past(grant)));  // R7

  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    sliceLen != '0);  // R6

  AST_LEN_HELD_IN_SLICE: assert property (@(posedge clk) disable iff (!rstN)
    !switchPulse |-> $stable(sliceLen));  // R3

endmodule

bind timeslice_arbiter tsa_checker #(.DRIFT_W(DRIFT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .grant      (grant),
  .sliceLen   (sliceLen),
  .switchPulse(switchPulse)
);

// File: tb/timeslice_arbiter_tb.sv
`timescale 1ns/1ps
module timeslice_arbiter_tb;

  localparam int DRIFT_W = 24;
  localparam int TICK_W  = 12;
  localparam int NOM     = 2048;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [TICK_W-1:0]  tickCnt = '0;
  logic [1:0]         grant;
  logic [DRIFT_W-1:0] sliceLen;
  logic               switchPulse;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // Behavioural reference state
  int  mDrift, mLen, mElapsed, mPulse;
  bit  mFast;

  always #5 clk = ~clk;

  timeslice_arbiter #(.DRIFT_W(DRIFT_W), .TICK_W(TICK_W), .NOMINAL(NOM)) u_dut (
    .clk(clk), .rstN(rstN), .tickCnt(tickCnt),
    .grant(grant), .sliceLen(sliceLen), .switchPulse(switchPulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mDrift = 0; mLen = NOM; mElapsed = 0; mFast = 1; mPulse = 0;
  endtask

  task automatic compareAll();
    chk("R3/R8 grant", int'(grant), mFast ? 1 : 2);
    chk("R4/R5/R6 sliceLen", int'(sliceLen), mLen);
    chk("R7 switchPulse", int'(switchPulse), mPulse);
  endtask

  // Called at a negedge: apply tick, advance model, compare at next negedge.
  task automatic step(input int t);
    int total;
    tickCnt = TICK_W'(t);
    total = mElapsed + t;
    mPulse = 0;
    if (mFast && total >= mLen) begin
      mDrift = mDrift + total;
      mLen = mDrift >>> 1;
      if (mLen <= 0) mLen = 1;
      mFast = 0; mElapsed = 0; mPulse = 1;
    end else if (!mFast && total >= 2 * mLen) begin
      mDrift = mDrift - (total / 2) * 2;
      mLen = mDrift + NOM;
      if (mLen <= 0) mLen = 1;
      mFast = 1; mElapsed = 0; mPulse = 1;
    end else begin
      mElapsed = total;
    end
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic doReset();
    rstN = 1'b0;
    tickCnt = '0;
    modelReset();
    @(negedge clk);
    chk("R1 grant in reset", int'(grant), 1);
    chk("R1 sliceLen in reset", int'(sliceLen), NOM);
    chk("R1 pulse in reset", int'(switchPulse), 0);
    rstN = 1'b1;
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();

    // R2: zero ticks advance nothing
    for (int i = 0; i < 10; i++) step(0);
    chk("R2 zero tick keeps fast grant", int'(grant), 1);

    // R3: unit ticks, switch exactly at 2048 fast cycles
    for (int i = 0; i < 2047; i++) step(1);
    chk("R3 no switch at 2047", int'(grant), 1);
    step(1);
    chk("R3 switch at 2048", int'(grant), 2);
    chk("R4 slow len 1024", int'(sliceLen), 1024);
    chk("R7 pulse on switch", int'(switchPulse), 1);
    step(0);
    chk("R7 pulse one clock", int'(switchPulse), 0);

    // Slow slice of 1024 needs 2048 fast cycles: 2047 then large overshoot
    step(2047);
    chk("R3 slow holds at 2047", int'(grant), 2);
    step(4095);
    // drift = 2048 - 6142 = -4094 -> fast len clamps to 1
    chk("R6 clamp after big overshoot", int'(sliceLen), 1);
    chk("R5 grant back to fast", int'(grant), 1);
    step(1);
    // drift -4093 -> arithmetic shift -2047 -> clamp 1
    chk("R6 negative shift clamps", int'(sliceLen), 1);
    chk("R3 grant slow", int'(grant), 2);
    step(1);
    chk("R3 slow of 1 needs two fast", int'(grant), 2);
    step(1);
    chk("R5 slow end even count", int'(grant), 1);

    // Fresh reset, then exact 2048 tick and odd overshoot on slow side
    doReset();
    step(2048);
    chk("R4 exact tick len", int'(sliceLen), 1024);
    step(2049);
    // drift = 2048 - 2048 = 0 -> len 2048
    chk("R5 odd count rounded down", int'(sliceLen), 2048);
    step(2000);
    step(47);
    chk("R9 overshoot not carried", int'(grant), 1);
    step(1);
    chk("R9 switch at fresh count", int'(grant), 2);

    // Random tick streams, reference compared every clock
    for (int i = 0; i < 30000; i++) step($urandom_range(0, 63));
    for (int i = 0; i < 2000; i++) step($urandom_range(0, 4095));
    for (int i = 0; i < 8000; i++) step($urandom_range(0, 63));

    doReset();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule